// File: doc/BRIEF.md
# Multichannel TDM DMA Buffer Mapper

This block sits between a time-division multichannel serial port and a DMA engine. The serial port marks each frame with a frame-sync strobe and each channel slot with a slot strobe. For every slot the block decides whether a DMA word transfer happens, separately for the transmit and the receive direction. It also produces the word offset inside the frame and the buffer address for that transfer. Serial shifting, clock generation and the DMA engine itself are outside the block.

Each direction has its own channel-enable mask and its own pack setting. In the unpacked layout, which is the reset default, the buffer holds one word for every slot of the window. The word for channel k is at offset k, and disabled channels are skipped. In the packed layout, only enabled channels take buffer words, and they are stored consecutively. A single multichannel enable, combined with the port enable, starts or stops both directions together.

A shared slot walker is a three-state machine with the states WK_OFF, WK_HUNT and WK_SLOTS:
- WK_OFF to WK_HUNT when the port starts running.
- WK_HUNT to WK_SLOTS on a frame sync.
- WK_SLOTS to WK_SLOTS on a frame sync, which restarts the window.
- WK_SLOTS to WK_HUNT on the last slot of the window.
- Any state to WK_OFF when running stops.

Top module: `tdm_dma_slot_mapper`

## Requirements
- R1: When `port_en` or `mc_en` is low, neither direction issues a request and `frame_done` stays low. Both directions start and stop together, and all outputs are low after reset.
- R2: `tx_pack` and `rx_pack` (1 = packed, 0 = unpacked) are independent per direction. They are sampled only while the port is stopped, and changing them while running has no effect.
- R3: In packed mode, the enabled channels inside the window receive offsets 0, 1, 2, … in ascending slot order. The offset count restarts at every frame sync.
- R4: The window length is (`win_blocks`+1)×8 slots (8 to 128) and is sampled while stopped. Slot strobes after the last slot and before the next frame sync are ignored. `frame_done` pulses in the same cycle that the request for the last slot would appear.
- R5: In packed mode, a mask write while running is refused. It is discarded and never takes effect later.
- R6: In unpacked mode, the offset equals the channel index. A slot whose mask bit is 0 produces no request in either mode.
- R7: In unpacked mode, a mask write while running is held back and takes effect at the next frame sync. The frame in progress finishes with the old mask.
- R8: A mask write while the port is stopped takes effect immediately.
- R9: The address is base + offset, modulo 2^ADDR_W. The base is 0 when running starts. After each completed window, the base advances by the number of enabled channels in the window (packed) or by the window length (unpacked). A window cut short by a frame sync does not advance the base.
- R10: A slot strobe before the first frame sync after starting is ignored. When a frame sync and a slot strobe arrive in the same cycle, the frame sync wins and the slot strobe is ignored.
- R11: A request appears on the second rising edge, counting the edge that samples the slot strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port running |
| mc_en | input | 1 | Multichannel mode for both directions |
| win_blocks | input | BLK_W | Window length in units of 8 slots, minus one |
| fsync | input | 1 | Frame-sync strobe |
| slot_stb | input | 1 | Slot strobe |
| tx_pack | input | 1 | Transmit packed layout select |
| rx_pack | input | 1 | Receive packed layout select |
| tx_mask_wr | input | 1 | Transmit mask write strobe |
| tx_mask_data | input | 8<<BLK_W | Transmit channel-enable mask |
| rx_mask_wr | input | 1 | Receive mask write strobe |
| rx_mask_data | input | 8<<BLK_W | Receive channel-enable mask |
| tx_req | output | 1 | Transmit DMA word request |
| tx_ofs | output | BLK_W+3 | Transmit word offset within frame |
| tx_addr | output | ADDR_W | Transmit buffer address |
| rx_req | output | 1 | Receive DMA word request |
| rx_ofs | output | BLK_W+3 | Receive word offset within frame |
| rx_addr | output | ADDR_W | Receive buffer address |
| frame_done | output | 1 | Last slot of window completed |

## Verification
A walker slot counter that drifts shows up within one frame, because the offsets or the `frame_done` pulse land on the wrong strobe. A stale or prematurely applied mask shows up as a request for a disabled channel, or a missing one, on the very next affected slot. A base register that advances by the wrong step stays hidden inside the first frame. It surfaces as a wrong address on the first request of the following frame, which is why the scoreboard always runs at least two complete windows per configuration.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;

    typedef enum logic [1:0] {
        WK_OFF   = 2'd0,
        WK_HUNT  = 2'd1,
        WK_SLOTS = 2'd2
    } walk_state_t;

endpackage

// File: rtl/tdm_slot_walker.sv
module tdm_slot_walker
    import tdm_map_pkg::*;
#(
    parameter int BLK_W  = 4,
    parameter int SLOT_W = BLK_W + 3,
    parameter int LEN_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BLK_W-1:0]  win_blocks,
    input  logic              fsync,
    input  logic              slot_stb,
    output logic              slot_fire,
    output logic [SLOT_W-1:0] slot_num,
    output logic              frame_start,
    output logic              frame_end,
    output logic [LEN_W-1:0]  win_len
);

    walk_state_t       state_q, state_d;
    logic [SLOT_W-1:0] idx_q;
    logic              last_slot;

    assign last_slot = (LEN_W'(idx_q) + LEN_W'(1)) == win_len;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_OFF:   if (run) state_d = WK_HUNT;
            WK_HUNT:  if (fsync) state_d = WK_SLOTS;
            WK_SLOTS: begin
                if (fsync)                      state_d = WK_SLOTS;
                else if (slot_stb && last_slot) state_d = WK_HUNT;
            end
            default:  state_d = WK_OFF;
        endcase
        if (!run) state_d = WK_OFF;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WK_OFF;
        else        state_q <= state_d;
    end

    // registered outputs and slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            slot_fire   <= 1'b0;
            slot_num    <= '0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            win_len     <= LEN_W'(8);
        end else begin
            slot_fire   <= 1'b0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            if (state_q == WK_OFF)
                win_len <= (LEN_W'(win_blocks) + LEN_W'(1)) << 3;
            if (run) begin
                unique case (state_q)
                    WK_HUNT: begin
                        if (fsync) begin
                            idx_q       <= '0;
                            frame_start <= 1'b1;
                        end
                    end
                    WK_SLOTS: begin
                        if (fsync) begin
                            idx_q       <= '0;
                            frame_start <= 1'b1;
                        end else if (slot_stb) begin
                            slot_fire <= 1'b1;
                            slot_num  <= idx_q;
                            frame_end <= last_slot;
                            idx_q     <= idx_q + SLOT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: a fired slot always lies inside the window
    assert_slot_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_fire |-> (LEN_W'(slot_num) < win_len));

    // R10: no slot fires unless a frame sync has opened the window
    assert_no_fire_before_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WK_SLOTS) |=> !slot_fire);

endmodule

// File: rtl/tdm_dir_path.sv
module tdm_dir_path #(
    parameter int SLOT_W = 7,
    parameter int LEN_W  = SLOT_W + 1,
    parameter int CH_MAX = 1 << SLOT_W,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pack_in,
    input  logic              mask_wr,
    input  logic [CH_MAX-1:0] mask_data,
    input  logic              frame_start,
    input  logic              slot_fire,
    input  logic [SLOT_W-1:0] slot_num,
    input  logic              frame_end,
    input  logic [LEN_W-1:0]  win_len,
    output logic              req,
    output logic [SLOT_W-1:0] ofs,
    output logic [ADDR_W-1:0] addr
);

    logic [CH_MAX-1:0] active_q, pend_q;
    logic              pend_v_q;
    logic              pack_cur;
    logic              run_d;
    logic [SLOT_W-1:0] pk_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  en_cnt, step;
    logic [SLOT_W-1:0] cur_ofs;

    // enabled channels that fall inside the window
    always_comb begin
        en_cnt = '0;
        for (int i = 0; i < CH_MAX; i++) begin
            if (active_q[i] && (LEN_W'(i) < win_len))
                en_cnt = en_cnt + LEN_W'(1);
        end
        step    = pack_cur ? en_cnt : win_len;
        cur_ofs = pack_cur ? pk_q : slot_num;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            pack_cur <= 1'b0;
            run_d    <= 1'b0;
            pk_q     <= '0;
            base_q   <= '0;
            req      <= 1'b0;
            ofs      <= '0;
            addr     <= '0;
        end else begin
            run_d <= run;
            req   <= 1'b0;
            if (!run) begin
                base_q   <= '0;
                pk_q     <= '0;
                pack_cur <= pack_in;
                pend_v_q <= 1'b0;
                if (pend_v_q) active_q <= pend_q;
                if (mask_wr)  active_q <= mask_data;
            end else begin
                if (frame_start) begin
                    pk_q <= '0;
                    if (pend_v_q) begin
                        active_q <= pend_q;
                        pend_v_q <= 1'b0;
                    end
                end
                if (slot_fire) begin
                    if (active_q[slot_num]) begin
                        req  <= 1'b1;
                        ofs  <= cur_ofs;
                        addr <= base_q + ADDR_W'(cur_ofs);
                        if (pack_cur) pk_q <= pk_q + SLOT_W'(1);
                    end
                    if (frame_end) base_q <= base_q + ADDR_W'(step);
                end
                // packed layout refuses writes while running
                if (mask_wr && !pack_cur) begin
                    pend_q   <= mask_data;
                    pend_v_q <= 1'b1;
                end
            end
        end
    end

    // R6: a disabled channel never yields a request
    assert_skip_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fire && !active_q[slot_num]) |=> !req);

    // R5: the mask in use is frozen while running packed
    assert_packed_mask_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_d && pack_cur) |-> $stable(active_q));

    // R3: offsets never leave the window
    assert_ofs_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (LEN_W'(ofs) < win_len));

endmodule

// File: rtl/tdm_dma_slot_mapper.sv
module tdm_dma_slot_mapper #(
    parameter int BLK_W  = 4,
    parameter int ADDR_W = 12,
    localparam int SLOT_W = BLK_W + 3,
    localparam int LEN_W  = SLOT_W + 1,
    localparam int CH_MAX = 8 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              mc_en,
    input  logic [BLK_W-1:0]  win_blocks,
    input  logic              fsync,
    input  logic              slot_stb,
    input  logic              tx_pack,
    input  logic              rx_pack,
    input  logic              tx_mask_wr,
    input  logic [CH_MAX-1:0] tx_mask_data,
    input  logic              rx_mask_wr,
    input  logic [CH_MAX-1:0] rx_mask_data,
    output logic              tx_req,
    output logic [SLOT_W-1:0] tx_ofs,
    output logic [ADDR_W-1:0] tx_addr,
    output logic              rx_req,
    output logic [SLOT_W-1:0] rx_ofs,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              frame_done
);

    localparam int NDIR = 2;

    logic              run;
    logic              wk_fire, wk_start, wk_end;
    logic [SLOT_W-1:0] wk_num;
    logic [LEN_W-1:0]  wk_len;
    logic              fd_q;

    logic              pack_v  [NDIR];
    logic              wr_v    [NDIR];
    logic [CH_MAX-1:0] mask_v  [NDIR];
    logic              req_v   [NDIR];
    logic [SLOT_W-1:0] ofs_v   [NDIR];
    logic [ADDR_W-1:0] addr_v  [NDIR];

    // one multichannel switch serves both directions
    assign run = port_en && mc_en;

    assign pack_v[0] = tx_pack;
    assign pack_v[1] = rx_pack;
    assign wr_v[0]   = tx_mask_wr;
    assign wr_v[1]   = rx_mask_wr;
    assign mask_v[0] = tx_mask_data;
    assign mask_v[1] = rx_mask_data;

    tdm_slot_walker #(
        .BLK_W (BLK_W),
        .SLOT_W(SLOT_W),
        .LEN_W (LEN_W)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .win_blocks (win_blocks),
        .fsync      (fsync),
        .slot_stb   (slot_stb),
        .slot_fire  (wk_fire),
        .slot_num   (wk_num),
        .frame_start(wk_start),
        .frame_end  (wk_end),
        .win_len    (wk_len)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        tdm_dir_path #(
            .SLOT_W(SLOT_W),
            .LEN_W (LEN_W),
            .CH_MAX(CH_MAX),
            .ADDR_W(ADDR_W)
        ) u_path (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (run),
            .pack_in    (pack_v[d]),
            .mask_wr    (wr_v[d]),
            .mask_data  (mask_v[d]),
            .frame_start(wk_start),
            .slot_fire  (wk_fire),
            .slot_num   (wk_num),
            .frame_end  (wk_end),
            .win_len    (wk_len),
            .req        (req_v[d]),
            .ofs        (ofs_v[d]),
            .addr       (addr_v[d])
        );
    end

    // align frame completion with the last slot's request
    always_ff @(posedge clk) begin
        if (!rst_n) fd_q <= 1'b0;
        else        fd_q <= run && wk_end;
    end

    assign tx_req     = req_v[0];
    assign tx_ofs     = ofs_v[0];
    assign tx_addr    = addr_v[0];
    assign rx_req     = req_v[1];
    assign rx_ofs     = ofs_v[1];
    assign rx_addr    = addr_v[1];
    assign frame_done = fd_q;

    // R1: stopping either enable silences both directions
    assert_stop_silences_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_en && mc_en) |=> !(tx_req || rx_req || frame_done));

endmodule

// File: tb/tdm_dma_slot_mapper_bench.sv
`timescale 1ns/1ps
module tdm_dma_slot_mapper_bench;

    localparam int BLK_W = 4;
    localparam int AW    = 12;
    localparam int SW    = BLK_W + 3;
    localparam int CH    = 8 << BLK_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          port_en = 1'b0, mc_en = 1'b0;
    logic [BLK_W-1:0] win_blocks = '0;
    logic          fsync = 1'b0, slot_stb = 1'b0;
    logic          tx_pack = 1'b0, rx_pack = 1'b0;
    logic          tx_mask_wr = 1'b0, rx_mask_wr = 1'b0;
    logic [CH-1:0] tx_mask_data = '0, rx_mask_data = '0;
    logic          tx_req, rx_req, frame_done;
    logic [SW-1:0] tx_ofs, rx_ofs;
    logic [AW-1:0] tx_addr, rx_addr;

    always #2 clk = ~clk;

    tdm_dma_slot_mapper #(.BLK_W(BLK_W), .ADDR_W(AW)) u_tdm_dma_slot_mapper (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .mc_en(mc_en),
        .win_blocks(win_blocks), .fsync(fsync), .slot_stb(slot_stb),
        .tx_pack(tx_pack), .rx_pack(rx_pack),
        .tx_mask_wr(tx_mask_wr), .tx_mask_data(tx_mask_data),
        .rx_mask_wr(rx_mask_wr), .rx_mask_data(rx_mask_data),
        .tx_req(tx_req), .tx_ofs(tx_ofs), .tx_addr(tx_addr),
        .rx_req(rx_req), .rx_ofs(rx_ofs), .rx_addr(rx_addr),
        .frame_done(frame_done)
    );

    typedef struct {
        int    ofs;
        int    addr;
        string tag;
    } exp_t;

    exp_t  q0[$];
    exp_t  q1[$];
    string fdq[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_tag = "R1";

    // reference model state
    bit            m_run = 1'b0;
    bit            m_pack [2];
    int            m_win = 8;
    logic [CH-1:0] m_act  [2];
    logic [CH-1:0] m_pend [2];
    bit            m_pv   [2];
    bit            m_inf = 1'b0;
    int            m_idx = 0;
    int            m_pk   [2];
    int            m_base [2];

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(int d, int o, int a);
        exp_t e;
        e.ofs = o; e.addr = a; e.tag = cur_tag;
        if (d == 0) q0.push_back(e);
        else        q1.push_back(e);
    endtask

    function automatic int en_in_win(int d);
        int c = 0;
        for (int i = 0; i < m_win; i++) if (m_act[d][i]) c++;
        return c;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && !done) begin
            if (tx_req) begin
                if (q0.size() == 0) check(1'b0, "R6", "unexpected tx request ofs", int'(tx_ofs), -1);
                else begin
                    e = q0.pop_front();
                    check(int'(tx_ofs) == e.ofs, e.tag, "tx offset", int'(tx_ofs), e.ofs);
                    check(int'(tx_addr) == e.addr, e.tag, "tx address", int'(tx_addr), e.addr);
                end
            end
            if (rx_req) begin
                if (q1.size() == 0) check(1'b0, "R6", "unexpected rx request ofs", int'(rx_ofs), -1);
                else begin
                    e = q1.pop_front();
                    check(int'(rx_ofs) == e.ofs, e.tag, "rx offset", int'(rx_ofs), e.ofs);
                    check(int'(rx_addr) == e.addr, e.tag, "rx address", int'(rx_addr), e.addr);
                end
            end
            if (frame_done) begin
                if (fdq.size() == 0) check(1'b0, "R4", "unexpected frame_done", 1, 0);
                else void'(fdq.pop_front());
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_run(bit pe, bit me, bit txp, bit rxp, int blocks);
        bit nr;
        @(negedge clk);
        port_en = pe; mc_en = me; tx_pack = txp; rx_pack = rxp;
        win_blocks = BLK_W'(blocks);
        nr = pe && me;
        if (!nr) begin
            m_pack[0] = txp; m_pack[1] = rxp; m_win = (blocks + 1) * 8;
            for (int d = 0; d < 2; d++) begin
                m_base[d] = 0; m_pk[d] = 0;
                if (m_pv[d]) m_act[d] = m_pend[d];
                m_pv[d] = 1'b0;
            end
            m_inf = 1'b0;
        end else if (!m_run) begin
            m_inf = 1'b0;
            for (int d = 0; d < 2; d++) m_base[d] = 0;
        end
        m_run = nr;
    endtask

    task automatic write_mask(int d, logic [CH-1:0] data);
        @(negedge clk);
        if (d == 0) begin tx_mask_wr = 1'b1; tx_mask_data = data; end
        else        begin rx_mask_wr = 1'b1; rx_mask_data = data; end
        if (!m_run) begin
            m_act[d] = data; m_pv[d] = 1'b0;
        end else if (!m_pack[d]) begin
            m_pend[d] = data; m_pv[d] = 1'b1;
        end
        @(negedge clk);
        tx_mask_wr = 1'b0; rx_mask_wr = 1'b0;
    endtask

    task automatic do_sync(bit with_slot);
        @(negedge clk);
        fsync = 1'b1; slot_stb = with_slot;
        if (m_run) begin
            m_inf = 1'b1; m_idx = 0;
            for (int d = 0; d < 2; d++) begin
                m_pk[d] = 0;
                if (m_pv[d]) begin m_act[d] = m_pend[d]; m_pv[d] = 1'b0; end
            end
        end
        @(negedge clk);
        fsync = 1'b0; slot_stb = 1'b0;
    endtask

    task automatic do_slot();
        int o;
        @(negedge clk);
        slot_stb = 1'b1;
        if (m_run && m_inf) begin
            for (int d = 0; d < 2; d++) begin
                if (m_act[d][m_idx]) begin
                    o = m_pack[d] ? m_pk[d] : m_idx;
                    push(d, o, (m_base[d] + o) % (1 << AW));
                    if (m_pack[d]) m_pk[d]++;
                end
            end
            if (m_idx == m_win - 1) begin
                fdq.push_back(cur_tag);
                for (int d = 0; d < 2; d++)
                    m_base[d] += m_pack[d] ? en_in_win(d) : m_win;
                m_inf = 1'b0;
            end
            m_idx++;
        end
        @(negedge clk);
        slot_stb = 1'b0;
    endtask

    task automatic slots(int n);
        for (int i = 0; i < n; i++) do_slot();
    endtask

    task automatic drained(string tag);
        idle(4);
        check(q0.size() == 0, tag, "pending tx expectations", q0.size(), 0);
        check(q1.size() == 0, tag, "pending rx expectations", q1.size(), 0);
        check(fdq.size() == 0, tag, "pending frame_done", fdq.size(), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "R1", "watchdog expired cycles", 100000, 0);
            summary();
            $finish;
        end
    end

    initial begin : stim
        for (int d = 0; d < 2; d++) begin
            m_pack[d] = 0; m_act[d] = '0; m_pend[d] = '0; m_pv[d] = 0;
            m_pk[d] = 0; m_base[d] = 0;
        end
        idle(5);
        // R1: reset state
        check(tx_req == 1'b0, "R1", "tx_req after reset", int'(tx_req), 0);
        check(rx_req == 1'b0, "R1", "rx_req after reset", int'(rx_req), 0);
        check(frame_done == 1'b0, "R1", "frame_done after reset", int'(frame_done), 0);
        rst_n = 1'b1;
        idle(2);

        // R8: stopped writes apply at once; window 16, tx unpacked, rx packed
        cur_tag = "R8";
        set_run(0, 0, 0, 1, 1);
        write_mask(0, (CH'(1) << 1) | (CH'(1) << 10));
        write_mask(1, (CH'(1) << 0) | (CH'(1) << 3) | (CH'(1) << 5) | (CH'(1) << 6));
        idle(2);
        set_run(1, 1, 0, 1, 1);

        // R10: slots before the first sync are ignored
        cur_tag = "R10";
        slots(3);
        drained("R10");

        // R11: latency of the first request, then R3/R6 on the rest of the frame
        cur_tag = "R11";
        do_sync(0);
        do_slot();
        check(rx_req == 1'b0, "R11", "rx_req one edge after strobe", int'(rx_req), 0);
        @(negedge clk);
        check(rx_req == 1'b1, "R11", "rx_req two edges after strobe", int'(rx_req), 1);
        cur_tag = "R6";
        slots(15);
        // R4: strobes past the window are ignored
        cur_tag = "R4";
        slots(2);
        drained("R4");

        // R9: second frame moves both bases
        cur_tag = "R9";
        do_sync(0);
        slots(16);
        drained("R9");

        // R7 / R5: running writes, unpacked deferred, packed refused
        cur_tag = "R7";
        do_sync(0);
        slots(5);
        write_mask(0, (CH'(1) << 2) | (CH'(1) << 15));
        write_mask(1, CH'(1) << 1);
        slots(11);
        drained("R7");

        // R2: pack flips while running are ignored
        cur_tag = "R2";
        set_run(1, 1, 1, 0, 1);
        cur_tag = "R5";
        do_sync(0);
        slots(16);
        drained("R5");

        // R10: coincident sync and slot; R9: cut-short window keeps base
        cur_tag = "R10";
        do_sync(1);
        slots(4);
        do_sync(0);
        cur_tag = "R9";
        slots(16);
        drained("R9");

        // R1: multichannel off silences both directions
        cur_tag = "R1";
        set_run(1, 0, 0, 1, 1);
        do_sync(0);
        slots(16);
        drained("R1");

        // R3 / R4: full 128-slot window, tx packed, rx unpacked
        cur_tag = "R3";
        set_run(0, 0, 1, 0, 15);
        write_mask(0, (CH'(1) << 0) | (CH'(1) << 7) | (CH'(1) << 127));
        write_mask(1, (CH'(1) << 64) | (CH'(1) << 127));
        idle(3);
        set_run(1, 1, 1, 0, 15);
        do_sync(0);
        slots(128);
        cur_tag = "R4";
        do_sync(0);
        slots(128);
        drained("R4");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule